// File: doc/BRIEF.md
# Windowed Microcontroller Watchdog

This block supervises a microcontroller by alternating a closed window, in which a service trigger is forbidden, with an open window, in which one is expected. Window lengths come from two 7-bit codes counted in steps of `STEP` clock cycles. When supervision is switched on, the block first grants one long open window of fixed maximum length, so the software has time to start and fall into step. After that the windows follow each other as long as the block stays enabled.

The trigger comes from one of two sources, selected by an input: a sampled pin, on which a valid trigger is a high-high-low-low sample pattern, or a one-cycle command pulse from the register interface. A 4-bit saturating error counter goes up on every missed or early trigger and down on every good one. When an error pushes the count above a programmable threshold, the block emits a one-cycle soft-reset request for the system controller. A sticky flag records that at least one error has occurred.

Top module: `wdog_window`

## Requirements
- R1: During reset, and on the edge after `enable` is seen low, `win_open`, `err_level`, `rst_req` are 0 (miss flag only after reset); while disabled, triggers from either source have no effect.
- R2: On the first edge with `enable` high the block opens a long window of 127*`STEP` cycles; a valid trigger inside it ends it at once.
- R3: A normal open window lasts `ow_code`*`STEP` cycles, with code 0 giving `STEP` cycles.
- R4: A closed window lasts `cw_code`*`STEP` cycles; with code 0 a valid trigger in an open window starts the next open window directly, with no closed cycles.
- R5: A valid trigger in an open window lowers `err_level` by 1 unless it is 0, and starts the closed window on the same edge.
- R6: An open window that ends without a valid trigger raises `err_level` by 1 and starts a new open window.
- R7: A valid trigger in a closed window raises `err_level` by 1 and starts a new open window.
- R8: `err_level` saturates at 15.
- R9: `rst_req` is a one-cycle pulse issued on the edge where an error leaves `err_level` above `err_thresh`; at or below the threshold no pulse is issued.
- R10: With `trig_sel`=0, a pin trigger is valid on the edge that samples the second low after at least two consecutive high samples (pattern 1,1,0,0 oldest first), and not before.
- R11: With `trig_sel`=0 the command pulse `cmd_trig` is ignored; with `trig_sel`=1 the pin is ignored.
- R12: `miss_flag` is set by every error and held until `miss_clr`; an error in the same cycle wins over the clear.
- R13: The window codes are taken only when a window starts; changing them mid-window does not alter the running window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one watchdog cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Supervision on; low clears windows and error count |
| trig_sel | input | 1 | Trigger source: 0 pin, 1 command |
| wdi_pin | input | 1 | Trigger pin, sampled every cycle |
| cmd_trig | input | 1 | One-cycle trigger command |
| ow_code | input | 7 | Open window size code |
| cw_code | input | 7 | Closed window size code |
| err_thresh | input | 4 | Error threshold for the reset request |
| miss_clr | input | 1 | Clears the sticky miss flag |
| win_open | output | 1 | High during any open window |
| err_level | output | 4 | Error counter value |
| miss_flag | output | 1 | Sticky error indication |
| rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The checker watches, on every cycle, that the error count moves by at most one step while enabled, that any rise comes with the miss flag set, that the miss flag only drops through a clear, that a reset request only appears with the count above the threshold, that disabling empties the state, and that no open stretch without a count change outlasts the long window. Exact window lengths, the code-0 corner cases, the pin pattern timing, source selection, saturation and the latching of codes at window start are only visible from the bench's timed scenarios.

// File: rtl/wdog_window.sv
`timescale 1ns/1ps
module wdog_window #(
  parameter int STEP   = 50,
  parameter int CODE_W = 7,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              trig_sel,
  input  logic              wdi_pin,
  input  logic              cmd_trig,
  input  logic [CODE_W-1:0] ow_code,
  input  logic [CODE_W-1:0] cw_code,
  input  logic [ERR_W-1:0]  err_thresh,
  input  logic              miss_clr,
  output logic              win_open,
  output logic [ERR_W-1:0]  err_level,
  output logic              miss_flag,
  output logic              rst_req
);
  localparam int LONG_LEN = ((1 << CODE_W) - 1) * STEP;
  localparam int TW = $clog2(LONG_LEN + 1);
  localparam logic [TW-1:0] LONG_LAST = TW'(LONG_LEN - 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  typedef enum logic [1:0] {S_OFF, S_LONG, S_OPEN, S_SHUT} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [2:0]       hist;
  logic [ERR_W-1:0] err;

  function automatic logic [TW-1:0] last_of(input logic [CODE_W-1:0] c, input logic floor1);
    int n;
    n = (c == '0 && floor1) ? 1 : int'(c);
    return TW'(n * STEP - 1);
  endfunction

  wire              pin_ok   = hist[2] & hist[1] & ~hist[0] & ~wdi_pin;
  wire              trig     = enable & (trig_sel ? cmd_trig : pin_ok);
  wire              is_open  = (st == S_LONG) || (st == S_OPEN);
  wire              expire   = (tmr == '0);
  wire              err_evt  = enable & ((is_open & ~trig & expire) | ((st == S_SHUT) & trig));
  wire [ERR_W-1:0]  err_up   = (err == ERR_MAX) ? err : err + 1'b1;
  wire [TW-1:0]     open_last = last_of(ow_code, 1'b1);
  wire [TW-1:0]     shut_last = last_of(cw_code, 1'b0);

  assign win_open  = is_open;
  assign err_level = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      tmr       <= '0;
      hist      <= '0;
      err       <= '0;
      miss_flag <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      hist    <= {hist[1:0], wdi_pin};
      rst_req <= 1'b0;
      if (err_evt) begin
        miss_flag <= 1'b1;
        err       <= err_up;
        rst_req   <= (err_up > err_thresh);
      end else if (miss_clr) begin
        miss_flag <= 1'b0;
      end
      if (!enable) begin
        st  <= S_OFF;
        tmr <= '0;
        err <= '0;
      end else begin
        case (st)
          S_OFF: begin
            st  <= S_LONG;
            tmr <= LONG_LAST;
          end
          S_LONG, S_OPEN: begin
            if (trig) begin
              if (err != '0) err <= err - 1'b1;
              if (cw_code == '0) begin
                st  <= S_OPEN;
                tmr <= open_last;
              end else begin
                st  <= S_SHUT;
                tmr <= shut_last;
              end
            end else if (expire) begin
              st  <= S_OPEN;
              tmr <= open_last;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          default: begin
            if (trig || expire) begin
              st  <= S_OPEN;
              tmr <= open_last;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/wdog_window_chk.sv
`timescale 1ns/1ps
module wdog_window_chk #(
  parameter int STEP   = 50,
  parameter int CODE_W = 7,
  parameter int ERR_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [ERR_W-1:0] err_thresh,
  input logic             miss_clr,
  input logic             win_open,
  input logic [ERR_W-1:0] err_level,
  input logic             miss_flag,
  input logic             rst_req
);
  localparam int LONG_LEN = ((1 << CODE_W) - 1) * STEP;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  int               run;
  logic [ERR_W-1:0] prev_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 0;
      prev_err <= '0;
    end else begin
      prev_err <= err_level;
      if (!win_open || err_level != prev_err || err_level == ERR_MAX || err_level == '0)
        run <= 0;
      else
        run <= run + 1;
    end
  end

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> ({1'b0, err_level} == {1'b0, $past(err_level)} ||
                       {1'b0, err_level} == {1'b0, $past(err_level)} + 1 ||
                       {1'b0, err_level} + 1 == {1'b0, $past(err_level)}));

  // R9
  rst_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (err_level > $past(err_thresh)));

  // R12
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_flag && !miss_clr) |=> miss_flag);

  // R12
  rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && err_level > $past(err_level)) |-> miss_flag);

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!win_open && err_level == '0));

  // R2
  open_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= LONG_LEN);
endmodule

bind wdog_window wdog_window_chk #(.STEP(STEP), .CODE_W(CODE_W), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .err_thresh(err_thresh),
  .miss_clr(miss_clr), .win_open(win_open), .err_level(err_level),
  .miss_flag(miss_flag), .rst_req(rst_req)
);

// File: tb/wdog_window_tb_top.sv
`timescale 1ns/1ps
module wdog_window_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, trig_sel = 1'b1, wdi_pin = 1'b0, cmd_trig = 1'b0, miss_clr = 1'b0;
  logic [6:0] ow_code = 7'd2, cw_code = 7'd1;
  logic [3:0] err_thresh = 4'd2;
  logic       win_open, miss_flag, rst_req;
  logic [3:0] err_level;

  int total = 0, bad = 0, rst_seen = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  wdog_window #(.STEP(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig_sel(trig_sel), .wdi_pin(wdi_pin),
    .cmd_trig(cmd_trig), .ow_code(ow_code), .cw_code(cw_code), .err_thresh(err_thresh),
    .miss_clr(miss_clr), .win_open(win_open), .err_level(err_level),
    .miss_flag(miss_flag), .rst_req(rst_req)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic nx(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic wait_err(input int v, input int lim);
    for (int i = 0; i < lim && int'(err_level) != v; i++) nx(1);
  endtask

  // monitor: every change of the error count is compared against the queue
  initial begin
    logic [3:0] last = 4'd0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rst_req) rst_seen++;
        if (err_level != last) begin
          if (exp_q.size() == 0) chk("R6 unexpected count change", int'(err_level), int'(last));
          else chk(tag_q.pop_front(), int'(err_level), exp_q.pop_front());
        end
        last = err_level;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    nx(3);
    chk("R1 reset win_open", win_open, 0);
    chk("R1 reset err_level", err_level, 0);
    chk("R1 reset miss_flag", miss_flag, 0);
    chk("R1 reset rst_req", rst_req, 0);
    rst_n = 1'b1;
    nx(2);
    chk("R1 disabled win_open", win_open, 0);
    // long window
    push(1, "R6 long window miss");
    enable = 1'b1;
    nx(1);
    chk("R2 long window opens", win_open, 1);
    nx(507);
    chk("R2 long window still running", err_level, 0);
    nx(1);
    chk("R2 long window ends after 508", err_level, 1);
    chk("R12 miss flag set", miss_flag, 1);
    chk("R6 new open window", win_open, 1);
    // good command trigger
    push(0, "R5 decrement");
    cmd_trig = 1'b1;
    nx(1); cmd_trig = 1'b0;
    chk("R5 good trigger closes", win_open, 0);
    chk("R5 good trigger decrements", err_level, 0);
    // early trigger in closed window
    nx(1);
    push(1, "R7 early trigger");
    cmd_trig = 1'b1;
    nx(1); cmd_trig = 1'b0;
    chk("R7 early trigger reopens", win_open, 1);
    chk("R7 early trigger counts", err_level, 1);
    // open window length code 2 -> 8 cycles, threshold 2
    push(2, "R3 expiry");
    nx(7);
    chk("R3 open window still running", err_level, 1);
    nx(1);
    chk("R3 open window of 8 ends", err_level, 2);
    chk("R9 no request at threshold", rst_req, 0);
    push(3, "R9 expiry over threshold");
    nx(8);
    chk("R9 count above threshold", err_level, 3);
    chk("R9 request pulse", rst_req, 1);
    err_thresh = 4'd15;
    ow_code = 7'd20;
    push(4, "R13 old code used");
    nx(1);
    chk("R9 request lasts one cycle", rst_req, 0);
    nx(6);
    chk("R13 running window unchanged", err_level, 3);
    nx(1);
    chk("R13 running window kept length 8", err_level, 4);
    // pin source
    trig_sel = 1'b0;
    nx(1); cmd_trig = 1'b1;
    nx(1); cmd_trig = 1'b0; wdi_pin = 1'b1;
    nx(1); wdi_pin = 1'b0;
    nx(3);
    chk("R11 command ignored on pin source", win_open, 1);
    chk("R10 single high not a trigger", err_level, 4);
    wdi_pin = 1'b1;
    nx(1);
    nx(1); wdi_pin = 1'b0;
    push(3, "R10 pin trigger decrement");
    nx(1);
    chk("R10 no trigger at first low", win_open, 1);
    chk("R13 new code 20 applied", err_level, 4);
    nx(1);
    chk("R10 trigger at second low", win_open, 0);
    chk("R10 pin trigger decrements", err_level, 3);
    ow_code = 7'd0;
    push(4, "R3 code0 expiry");
    push(5, "R3 code0 expiry");
    wait_err(4, 100);
    n = 0;
    for (int i = 0; i < 50 && err_level != 4'd5; i++) begin nx(1); n++; end
    chk("R3 code 0 gives STEP cycles", n, 4);
    for (int v = 6; v <= 15; v++) push(v, "R8 count up");
    wait_err(15, 400);
    nx(40);
    chk("R8 saturation at 15", err_level, 15);
    chk("R12 flag still set", miss_flag, 1);
    // disable
    push(0, "R1 disable clears");
    enable = 1'b0;
    nx(1);
    chk("R1 disabled closes window", win_open, 0);
    chk("R1 disabled clears count", err_level, 0);
    miss_clr = 1'b1;
    nx(1); miss_clr = 1'b0;
    chk("R12 clear drops flag", miss_flag, 0);
    trig_sel = 1'b1; cmd_trig = 1'b1;
    nx(1); cmd_trig = 1'b0;
    nx(2);
    chk("R1 trigger ignored when disabled", win_open, 0);
    chk("R1 count unchanged when disabled", err_level, 0);
    // re-enable, pin ignored on command source, long window cut short
    enable = 1'b1;
    nx(1);
    chk("R2 long window reopens", win_open, 1);
    wdi_pin = 1'b1;
    nx(1);
    nx(1); wdi_pin = 1'b0;
    nx(2);
    chk("R11 pin ignored on command source", win_open, 1);
    chk("R11 count unchanged", err_level, 0);
    nx(4); cmd_trig = 1'b1;
    nx(1); cmd_trig = 1'b0;
    chk("R5 no decrement below zero", err_level, 0);
    chk("R2 trigger ends long window", win_open, 0);
    cw_code = 7'd0;
    nx(3);
    chk("R4 closed window of 4", win_open, 0);
    nx(1);
    chk("R4 closed window ends", win_open, 1);
    push(1, "R4 restarted window expiry");
    nx(1); cmd_trig = 1'b1;
    nx(1); cmd_trig = 1'b0;
    chk("R4 zero closed window stays open", win_open, 1);
    chk("R4 good trigger no error", err_level, 0);
    nx(3);
    chk("R4 window restarted by trigger", err_level, 0);
    nx(1);
    chk("R4 restarted window expires", err_level, 1);
    chk("R12 flag set again", miss_flag, 1);
    nx(2);
    chk("R6 all expected changes seen", exp_q.size(), 0);
    chk("R9 exactly one request", rst_seen, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule